// File: doc/BRIEF.md
# SMBus Host Protocol Sequencer

This block is the protocol engine of an SMBus host. Software fills a small byte-wide register file (command byte, target address with direction bit, two data bytes and a 32-entry block buffer) and then writes the control register with the start bit set. The engine expands the chosen protocol into a fixed list of byte-level bus operations. Each operation is offered on a valid/ready handshake to a downstream agent that owns the wire-level signalling.

Data received from the target is written back into the data registers or the block buffer. The status register shows whether a sequence is running, whether it has finished, whether the protocol code was not supported, and whether the target failed to acknowledge. The block buffer is reached through one data port whose index moves on every access. That index is reset as a side effect of two other register accesses.

Top module: `smb_host_engine`

## Requirements
- R1: After reset every register reads 0, the block buffer holds 0 in every entry, and `op_valid` is low.
- R2: The registers sit at these byte offsets: status 0, control 2, command 3, address 4, data0 5, data1 6, block port 7. Offset 1 reads 0. Reading control returns only its bits [4:0], with the upper bits read as 0.
- R3: A control write with bit 6 set starts the protocol coded in bits [4:2]. The address register holds the 7-bit target in [7:1] and the direction in bit 0 (1 = read). Status bit 0 is 1 while a sequence runs. Status bit 1 is set when the sequence ends.
- R4: Quick command (code 0) issues a start that carries the direction, then a stop. Byte send (code 1, write) issues a write start, then the command byte, then a stop. Byte receive (code 1, read) issues a read start, receives into data0, then issues a nack and a stop.
- R5: Byte data (code 2) and word (code 3) writes send the command, then data0, then data1 (word only), then a stop. Their reads send the command, issue a repeated start in read mode, receive into data0 and then data1 (word only, low byte first), then issue a nack and a stop.
- R6: A block write (code 5) sends the command, then a length equal to data0 clamped to 32, then that many buffer entries starting at entry 0, then a stop. Data0 itself is left unchanged.
- R7: A block read (code 5) sends the command and issues a repeated read start. The first received byte is the length, and a value above 32 is taken as 0. The length is stored in data0, and that many further bytes fill the buffer from entry 0. A nack and a stop follow.
- R8: Each read or write at the block port uses the entry at the current index and then moves the index by one. The index wraps from 31 to 0. Any status write or control read sets the index to 0.
- R9: Any write to the status register clears status bits 1, 2 and 3.
- R10: A start with a protocol code other than 0, 1, 2, 3 or 5 sets status bit 2 and issues no bus operation.
- R11: If the target does not acknowledge a start or a sent byte, the engine sets status bit 3, issues a stop at once, and then sets status bit 1.
- R12: A control write that arrives while a sequence runs is ignored completely. No new sequence starts, and the stored control value is kept.
- R13: An offered operation keeps `op_kind` and `op_byte` until `op_ready` is seen. The kind codes are: start-write 0, start-read 1, send 2, receive 3, nack 4, stop 5. A start carries {address[7:1], direction}. Every sequence ends with a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (side effects on the clock edge) |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| op_valid | output | 1 | A bus operation is offered |
| op_kind | output | 3 | Operation code |
| op_byte | output | 8 | Byte to send, or the address byte for a start |
| op_ready | input | 1 | Agent accepts the operation this cycle |
| op_ack | input | 1 | Target acknowledged (used for starts and sends) |
| op_rdata | input | 8 | Received byte (used for receives) |

## Verification
The bench goes after the block-length limits: a write length of 50 must put exactly 32 bytes on the bus, and a read length of 33 must become 0 and leave the buffer untouched. A clamp that is off by one would move a byte too many or store a bogus length. Buffer index wrapping and its reset by status writes and control reads are also targeted: a design that got these wrong would read back entries that are shifted. A control write made while a slow agent stalls a word transfer checks that the engine does not start a second sequence and does not overwrite the stored control value. A mismatched address checks that the engine stops at once and sets the no-acknowledge bit, rather than running on to the data phase.

// File: rtl/smb_host_pkg.sv
package smb_host_pkg;

    typedef enum logic [2:0] {
        OP_START_WR = 3'd0,
        OP_START_RD = 3'd1,
        OP_SEND     = 3'd2,
        OP_RECV     = 3'd3,
        OP_NACK     = 3'd4,
        OP_STOP     = 3'd5
    } bus_op_e;

    typedef enum logic [3:0] {
        S_IDLE, S_ADDR, S_CMD, S_WD0, S_WD1, S_WLEN, S_WBLK,
        S_RADDR, S_RD0, S_RD1, S_RLEN, S_RBLK, S_NACK, S_STOP
    } seq_st_e;

    localparam logic [2:0] REG_STAT = 3'd0;
    localparam logic [2:0] REG_CTRL = 3'd2;
    localparam logic [2:0] REG_CMD  = 3'd3;
    localparam logic [2:0] REG_ADDR = 3'd4;
    localparam logic [2:0] REG_DAT0 = 3'd5;
    localparam logic [2:0] REG_DAT1 = 3'd6;
    localparam logic [2:0] REG_BLK  = 3'd7;

    localparam int CTRL_GO_BIT = 6;

    localparam logic [2:0] PR_QUICK = 3'd0;
    localparam logic [2:0] PR_BYTE  = 3'd1;
    localparam logic [2:0] PR_BDATA = 3'd2;
    localparam logic [2:0] PR_WORD  = 3'd3;
    localparam logic [2:0] PR_BLOCK = 3'd5;

    // Write strobes from the sequencer into the register file
    typedef struct packed {
        logic       wr_d0;
        logic       wr_d1;
        logic       wr_buf;
        logic [7:0] data;
    } seq_wr_t;

    // Completion events reported to the status bits
    typedef struct packed {
        logic done;
        logic dev_err;
        logic proto_err;
    } seq_evt_t;

    function automatic logic proto_known(input logic [2:0] p);
        return (p == PR_QUICK) || (p == PR_BYTE) || (p == PR_BDATA) ||
               (p == PR_WORD) || (p == PR_BLOCK);
    endfunction

    function automatic logic [7:0] clamp_len(input logic [7:0] v, input logic [7:0] lim);
        return (v > lim) ? lim : v;
    endfunction

endpackage

// File: rtl/smb_regfile.sv
module smb_regfile
    import smb_host_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    parameter int IDX_W     = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [2:0]       reg_addr,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             busy,
    input  seq_wr_t          seq_wr,
    input  logic [IDX_W-1:0] seq_idx,
    input  seq_evt_t         ev,
    output logic             start_req,
    output logic [2:0]       start_prot,
    output logic [7:0]       cmd_q,
    output logic [7:0]       addr_q,
    output logic [7:0]       d0_q,
    output logic [7:0]       d1_q,
    output logic [7:0]       seq_buf_data
);

    logic [4:0]       ctl_q;
    logic             done_q, perr_q, derr_q;
    logic [IDX_W-1:0] blk_idx;
    logic [7:0]       blk_mem [BUF_DEPTH];

    logic wr_stat, wr_ctrl, rd_ctrl, blk_acc, host_blk_wr;

    assign wr_stat     = reg_wr && (reg_addr == REG_STAT);
    assign wr_ctrl     = reg_wr && (reg_addr == REG_CTRL) && !busy;
    assign rd_ctrl     = reg_rd && (reg_addr == REG_CTRL);
    assign host_blk_wr = reg_wr && (reg_addr == REG_BLK);
    assign blk_acc     = (reg_wr || reg_rd) && (reg_addr == REG_BLK);

    assign start_req    = wr_ctrl && reg_wdata[CTRL_GO_BIT];
    assign start_prot   = reg_wdata[4:2];
    assign seq_buf_data = blk_mem[seq_idx];

    // Plain registers; sequencer results take priority over host writes
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            cmd_q <= '0;
            addr_q <= '0;
            d0_q <= '0;
            d1_q <= '0;
        end else begin
            if (wr_ctrl) ctl_q <= reg_wdata[4:0];
            if (reg_wr && reg_addr == REG_CMD)  cmd_q  <= reg_wdata;
            if (reg_wr && reg_addr == REG_ADDR) addr_q <= reg_wdata;
            if (seq_wr.wr_d0) d0_q <= seq_wr.data;
            else if (reg_wr && reg_addr == REG_DAT0) d0_q <= reg_wdata;
            if (seq_wr.wr_d1) d1_q <= seq_wr.data;
            else if (reg_wr && reg_addr == REG_DAT1) d1_q <= reg_wdata;
        end
    end

    // Sticky status flags: clear on status write, events win on collision
    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            perr_q <= 1'b0;
            derr_q <= 1'b0;
        end else begin
            done_q <= (done_q && !wr_stat) || ev.done;
            perr_q <= (perr_q && !wr_stat) || ev.proto_err;
            derr_q <= (derr_q && !wr_stat) || ev.dev_err;
        end
    end

    // Block port index: reset has priority over stepping
    always_ff @(posedge clk) begin
        if (rst) begin
            blk_idx <= '0;
        end else if (wr_stat || rd_ctrl) begin
            blk_idx <= '0;
        end else if (blk_acc) begin
            blk_idx <= (blk_idx == IDX_W'(BUF_DEPTH - 1)) ? '0 : blk_idx + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < BUF_DEPTH; i++) blk_mem[i] <= '0;
        end else begin
            if (host_blk_wr) blk_mem[blk_idx] <= reg_wdata;
            if (seq_wr.wr_buf) blk_mem[seq_idx] <= seq_wr.data;
        end
    end

    always_comb begin
        case (reg_addr)
            REG_STAT: reg_rdata = {4'b0000, derr_q, perr_q, done_q, busy};
            REG_CTRL: reg_rdata = {3'b000, ctl_q};
            REG_CMD:  reg_rdata = cmd_q;
            REG_ADDR: reg_rdata = addr_q;
            REG_DAT0: reg_rdata = d0_q;
            REG_DAT1: reg_rdata = d1_q;
            REG_BLK:  reg_rdata = blk_mem[blk_idx];
            default:  reg_rdata = 8'h00;
        endcase
    end

    assert_ctl_frozen_R12: assert property (@(posedge clk) disable iff (rst)
        (busy && reg_wr && reg_addr == REG_CTRL) |=> $stable(ctl_q));

    assert_stat_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_stat && !ev.done && !ev.dev_err && !ev.proto_err) |=> (!done_q && !perr_q && !derr_q));

    assert_idx_home_R8: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr == REG_CTRL) |=> (blk_idx == '0));

endmodule

// File: rtl/smb_seq.sv
module smb_seq
    import smb_host_pkg::*;
#(
    parameter int BUF_DEPTH = 32,
    parameter int IDX_W     = 5,
    parameter int LEN_W     = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    input  logic [2:0]       start_prot,
    input  logic [7:0]       addr_q,
    input  logic [7:0]       cmd_q,
    input  logic [7:0]       d0_q,
    input  logic [7:0]       d1_q,
    input  logic [7:0]       buf_data,
    output logic             op_valid,
    output bus_op_e          op_kind,
    output logic [7:0]       op_byte,
    input  logic             op_ready,
    input  logic             op_ack,
    input  logic [7:0]       op_rdata,
    output logic             busy,
    output seq_wr_t          seq_wr,
    output logic [IDX_W-1:0] seq_idx,
    output seq_evt_t         ev
);

    localparam logic [7:0] DEPTH8 = 8'(BUF_DEPTH);

    seq_st_e    st, nxt;
    logic [2:0] prot_q;
    logic       rd_q;
    logic [6:0] addr7_q;
    logic [LEN_W-1:0] cnt, len_q;

    logic       fire, need_ack, first_rd, launch, last_blk;
    logic [7:0] wlen8, rlen8;

    assign busy     = (st != S_IDLE);
    assign op_valid = busy;
    assign fire     = op_valid && op_ready;
    assign launch   = (st == S_IDLE) && start_req && proto_known(start_prot);
    assign first_rd = rd_q && (prot_q == PR_QUICK || prot_q == PR_BYTE);
    assign wlen8    = clamp_len(d0_q, DEPTH8);
    assign rlen8    = (op_rdata > DEPTH8) ? 8'd0 : op_rdata;
    assign last_blk = (LEN_W'(cnt + 1'b1) == len_q);
    assign seq_idx  = cnt[IDX_W-1:0];

    always_comb begin
        need_ack = 1'b0;
        case (st)
            S_ADDR, S_RADDR, S_CMD, S_WD0, S_WD1, S_WLEN, S_WBLK: need_ack = 1'b1;
            default: need_ack = 1'b0;
        endcase
    end

    // Operation offered in each state
    always_comb begin
        op_kind = OP_STOP;
        op_byte = 8'h00;
        case (st)
            S_ADDR: begin
                op_kind = first_rd ? OP_START_RD : OP_START_WR;
                op_byte = {addr7_q, first_rd};
            end
            S_RADDR: begin
                op_kind = OP_START_RD;
                op_byte = {addr7_q, 1'b1};
            end
            S_CMD:  begin op_kind = OP_SEND; op_byte = cmd_q;    end
            S_WD0:  begin op_kind = OP_SEND; op_byte = d0_q;     end
            S_WD1:  begin op_kind = OP_SEND; op_byte = d1_q;     end
            S_WLEN: begin op_kind = OP_SEND; op_byte = wlen8;    end
            S_WBLK: begin op_kind = OP_SEND; op_byte = buf_data; end
            S_RD0, S_RD1, S_RLEN, S_RBLK: op_kind = OP_RECV;
            S_NACK: op_kind = OP_NACK;
            default: op_kind = OP_STOP;
        endcase
    end

    always_comb begin
        nxt = st;
        if (st == S_IDLE) begin
            if (launch) nxt = S_ADDR;
        end else if (fire) begin
            if (need_ack && !op_ack) begin
                nxt = S_STOP;
            end else begin
                case (st)
                    S_ADDR: begin
                        if (prot_q == PR_QUICK)     nxt = S_STOP;
                        else if (prot_q == PR_BYTE) nxt = rd_q ? S_RD0 : S_CMD;
                        else                        nxt = S_CMD;
                    end
                    S_CMD: begin
                        if (prot_q == PR_BYTE)       nxt = S_STOP;
                        else if (rd_q)               nxt = S_RADDR;
                        else if (prot_q == PR_BLOCK) nxt = S_WLEN;
                        else                         nxt = S_WD0;
                    end
                    S_WD0:   nxt = (prot_q == PR_WORD) ? S_WD1 : S_STOP;
                    S_WD1:   nxt = S_STOP;
                    S_WLEN:  nxt = (wlen8 == 8'd0) ? S_STOP : S_WBLK;
                    S_WBLK:  nxt = last_blk ? S_STOP : S_WBLK;
                    S_RADDR: nxt = (prot_q == PR_BLOCK) ? S_RLEN : S_RD0;
                    S_RD0:   nxt = (prot_q == PR_WORD) ? S_RD1 : S_NACK;
                    S_RD1:   nxt = S_NACK;
                    S_RLEN:  nxt = (rlen8 == 8'd0) ? S_NACK : S_RBLK;
                    S_RBLK:  nxt = last_blk ? S_NACK : S_RBLK;
                    S_NACK:  nxt = S_STOP;
                    default: nxt = S_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            prot_q  <= '0;
            rd_q    <= 1'b0;
            addr7_q <= '0;
            cnt     <= '0;
            len_q   <= '0;
        end else begin
            st <= nxt;
            if (launch) begin
                prot_q  <= start_prot;
                rd_q    <= addr_q[0];
                addr7_q <= addr_q[7:1];
            end
            if (fire) begin
                case (st)
                    S_WLEN: begin len_q <= wlen8[LEN_W-1:0]; cnt <= '0; end
                    S_RLEN: begin len_q <= rlen8[LEN_W-1:0]; cnt <= '0; end
                    S_WBLK, S_RBLK: cnt <= cnt + 1'b1;
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        seq_wr.wr_d0  = fire && (st == S_RD0 || st == S_RLEN);
        seq_wr.wr_d1  = fire && (st == S_RD1);
        seq_wr.wr_buf = fire && (st == S_RBLK);
        seq_wr.data   = (st == S_RLEN) ? rlen8 : op_rdata;
        ev.done       = fire && (st == S_STOP);
        ev.dev_err    = fire && need_ack && !op_ack;
        ev.proto_err  = (st == S_IDLE) && start_req && !proto_known(start_prot);
    end

    assert_op_hold_R13: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_ready) |=> (op_valid && $stable(op_kind)));

    assert_stop_last_R13: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(op_kind) == OP_STOP));

    assert_one_store_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({seq_wr.wr_d0, seq_wr.wr_d1, seq_wr.wr_buf}));

    assert_len_cap_R7: assert property (@(posedge clk) disable iff (rst)
        (len_q <= LEN_W'(BUF_DEPTH)));

    assert_start_gated_R12: assert property (@(posedge clk) disable iff (rst)
        busy |-> !start_req);

    assert_bad_code_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (start_req && !proto_known(start_prot)) |=> !busy);

endmodule

// File: rtl/smb_host_engine.sv
module smb_host_engine
    import smb_host_pkg::*;
#(
    parameter int BUF_DEPTH = 32
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [2:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       op_valid,
    output logic [2:0] op_kind,
    output logic [7:0] op_byte,
    input  logic       op_ready,
    input  logic       op_ack,
    input  logic [7:0] op_rdata
);

    localparam int IDX_W = (BUF_DEPTH > 1) ? $clog2(BUF_DEPTH) : 1;
    localparam int LEN_W = $clog2(BUF_DEPTH + 1);

    logic             busy, start_req;
    logic [2:0]       start_prot;
    logic [7:0]       cmd_q, addr_q, d0_q, d1_q, buf_data;
    logic [IDX_W-1:0] seq_idx;
    seq_wr_t          seq_wr;
    seq_evt_t         ev;
    bus_op_e          kind_e;

    assign op_kind = kind_e;

    smb_regfile #(.BUF_DEPTH(BUF_DEPTH), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst(rst),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .seq_wr(seq_wr), .seq_idx(seq_idx), .ev(ev),
        .start_req(start_req), .start_prot(start_prot),
        .cmd_q(cmd_q), .addr_q(addr_q), .d0_q(d0_q), .d1_q(d1_q),
        .seq_buf_data(buf_data)
    );

    smb_seq #(.BUF_DEPTH(BUF_DEPTH), .IDX_W(IDX_W), .LEN_W(LEN_W)) u_seq (
        .clk(clk), .rst(rst),
        .start_req(start_req), .start_prot(start_prot),
        .addr_q(addr_q), .cmd_q(cmd_q), .d0_q(d0_q), .d1_q(d1_q),
        .buf_data(buf_data),
        .op_valid(op_valid), .op_kind(kind_e), .op_byte(op_byte),
        .op_ready(op_ready), .op_ack(op_ack), .op_rdata(op_rdata),
        .busy(busy), .seq_wr(seq_wr), .seq_idx(seq_idx), .ev(ev)
    );

endmodule

// File: tb/smb_host_engine_test.sv
module smb_host_engine_test;

    localparam logic [6:0] DEV = 7'h2A;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       op_valid;
    logic [2:0] op_kind;
    logic [7:0] op_byte;
    logic       op_ready = 1'b0, op_ack = 1'b0;
    logic [7:0] op_rdata = 8'd0;

    smb_host_engine uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .op_valid(op_valid), .op_kind(op_kind), .op_byte(op_byte),
        .op_ready(op_ready), .op_ack(op_ack), .op_rdata(op_rdata)
    );

    always #5 clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    int log_kind [80], log_byte [80], log_n = 0;
    int exp_kind [80], exp_byte [80], exp_n = 0;
    logic [7:0] rx_q [64];
    int agent_rp = 0;
    logic [7:0] tb_buf [32];
    logic [7:0] exp_status, exp_d0, exp_d1;
    bit slow = 0;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++; bad++;
            $display("FAIL R13 watchdog expired actual=%0d expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Downstream agent: acks only DEV, supplies scripted receive bytes, logs ops
    initial begin
        int waitc, delay;
        waitc = 0; delay = 0;
        forever begin
            @(negedge clk);
            op_ready = 1'b0;
            if (op_valid && !rst) begin
                if (waitc < delay) waitc++;
                else begin
                    waitc = 0;
                    delay = slow ? 6 : int'($urandom % 3);
                    op_ready = 1'b1;
                    op_ack = (op_kind <= 3'd1) ? (op_byte[7:1] == DEV) : 1'b1;
                    op_rdata = (op_kind == 3'd3) ? rx_q[agent_rp % 64] : 8'h00;
                    if (op_kind == 3'd3) agent_rp++;
                    if (log_n < 80) begin
                        log_kind[log_n] = int'(op_kind);
                        log_byte[log_n] = int'(op_byte);
                        log_n++;
                    end
                end
            end
        end
    end

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic wait_idle();
        logic [7:0] s;
        for (int i = 0; i < 3000; i++) begin
            bus_rd(3'd0, s);
            if (!s[0]) return;
        end
    endtask

    task automatic push(input int k, input int b);
        exp_kind[exp_n] = k; exp_byte[exp_n] = b; exp_n++;
    endtask

    // Expected bus ops, status and data registers from the requirements
    task automatic gen_expected(input logic [2:0] p, input logic r, input logic [6:0] a7,
                                input logic [7:0] cmd, input logic [7:0] d0, input logic [7:0] d1);
        int rp, ln;
        logic fr;
        exp_n = 0; rp = 0;
        exp_d0 = d0; exp_d1 = d1;
        if (!(p == 0 || p == 1 || p == 2 || p == 3 || p == 5)) begin
            exp_status = 8'h04; return;
        end
        fr = r && (p <= 1);
        push(fr ? 1 : 0, {a7, fr});
        if (a7 != DEV) begin
            push(5, 0); exp_status = 8'h0A; return;
        end
        if (p == 1) begin
            if (r) begin exp_d0 = rx_q[rp]; rp++; push(3, 0); push(4, 0); end
            else push(2, cmd);
        end else if (p != 0) begin
            push(2, cmd);
            if (!r) begin
                if (p == 2) push(2, d0);
                if (p == 3) begin push(2, d0); push(2, d1); end
                if (p == 5) begin
                    ln = (d0 > 32) ? 32 : int'(d0);
                    push(2, ln);
                    for (int i = 0; i < ln; i++) push(2, tb_buf[i]);
                end
            end else begin
                push(1, {a7, 1'b1});
                if (p == 2) begin exp_d0 = rx_q[rp]; rp++; push(3, 0); end
                if (p == 3) begin
                    exp_d0 = rx_q[rp]; rp++; push(3, 0);
                    exp_d1 = rx_q[rp]; rp++; push(3, 0);
                end
                if (p == 5) begin
                    ln = (rx_q[rp] > 32) ? 0 : int'(rx_q[rp]); rp++;
                    exp_d0 = 8'(ln); push(3, 0);
                    for (int i = 0; i < ln; i++) begin
                        tb_buf[i] = rx_q[rp]; rp++; push(3, 0);
                    end
                end
                push(4, 0);
            end
        end
        push(5, 0);
        exp_status = 8'h02;
    endtask

    task automatic run_txn(input logic [2:0] p, input logic r, input logic [6:0] a7,
                           input logic [7:0] cmd, input logic [7:0] d0, input logic [7:0] d1,
                           input string req);
        logic [7:0] v;
        bus_wr(3'd3, cmd);
        bus_wr(3'd4, {a7, r});
        bus_wr(3'd5, d0);
        bus_wr(3'd6, d1);
        gen_expected(p, r, a7, cmd, d0, d1);
        log_n = 0; agent_rp = 0;
        bus_wr(3'd2, 8'h40 | {3'b000, p, 2'b00});
        wait_idle();
        chk(req, "op count", 16'(log_n), 16'(exp_n));
        for (int i = 0; i < exp_n && i < log_n; i++) begin
            chk(req, "op", 16'({log_kind[i][2:0], log_byte[i][7:0]}),
                16'({exp_kind[i][2:0], exp_byte[i][7:0]}));
        end
        bus_rd(3'd0, v); chk(req, "status", 16'(v), 16'(exp_status));
        bus_rd(3'd5, v); chk(req, "data0", 16'(v), 16'(exp_d0));
        bus_rd(3'd6, v); chk(req, "data1", 16'(v), 16'(exp_d1));
        bus_wr(3'd0, 8'h00);
        bus_rd(3'd0, v); chk("R9", "status after clear", 16'(v), 16'h0000);
        if (p == 5 && r && a7 == DEV) begin
            for (int i = 0; i < 32; i++) begin
                bus_rd(3'd7, v); chk("R7", "block entry", 16'(v), 16'(tb_buf[i]));
            end
        end
    endtask

    task automatic load_buf(input int seed_base);
        bus_wr(3'd0, 8'h00);
        for (int i = 0; i < 32; i++) begin
            tb_buf[i] = 8'(seed_base + i * 7);
            bus_wr(3'd7, tb_buf[i]);
        end
    endtask

    initial begin
        logic [7:0] v;
        logic [2:0] plist [12];
        void'($urandom(32'd20240611));
        plist = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd5, 3'd5, 3'd2, 3'd3, 3'd1, 3'd5, 3'd4, 3'd7};
        for (int i = 0; i < 64; i++) rx_q[i] = 8'h00;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1", "op_valid", 16'(op_valid), 16'h0);
        for (int a = 0; a < 7; a++) begin
            bus_rd(3'(a), v); chk("R1", "reset register", 16'(v), 16'h0);
        end
        bus_rd(3'd7, v); chk("R1", "reset buffer", 16'(v), 16'h0);

        // R2: control readback masks upper bits; no start without bit 6 (R3)
        bus_wr(3'd2, 8'hA3);
        chk("R3", "no start without go bit", 16'(op_valid), 16'h0);
        bus_rd(3'd2, v); chk("R2", "control readback", 16'(v), 16'h03);
        bus_rd(3'd1, v); chk("R2", "unused offset", 16'(v), 16'h00);

        // R8: wrap after 31, reset by control read and status write
        bus_wr(3'd0, 8'h00);
        for (int i = 0; i < 33; i++) bus_wr(3'd7, 8'(8'h10 + i));
        for (int i = 0; i < 32; i++) tb_buf[i] = 8'(8'h10 + i);
        tb_buf[0] = 8'h30;
        bus_rd(3'd2, v);
        for (int i = 0; i < 32; i++) begin
            bus_rd(3'd7, v); chk("R8", "wrapped entry", 16'(v), 16'(tb_buf[i]));
        end
        bus_rd(3'd7, v); chk("R8", "wrap on read", 16'(v), 16'(tb_buf[0]));
        bus_rd(3'd7, v);
        bus_rd(3'd7, v); chk("R8", "index step", 16'(v), 16'(tb_buf[2]));
        bus_wr(3'd0, 8'h00);
        bus_rd(3'd7, v); chk("R8", "index reset by status write", 16'(v), 16'(tb_buf[0]));

        // Directed protocol cases
        load_buf(8'h41);
        run_txn(3'd0, 1'b0, DEV, 8'h00, 8'h00, 8'h00, "R4");
        run_txn(3'd0, 1'b1, DEV, 8'h00, 8'h00, 8'h00, "R4");
        rx_q[0] = 8'h9C;
        run_txn(3'd1, 1'b1, DEV, 8'h11, 8'h00, 8'h00, "R4");
        run_txn(3'd3, 1'b0, DEV, 8'h22, 8'hA5, 8'h5A, "R5");
        rx_q[0] = 8'h34; rx_q[1] = 8'h12;
        run_txn(3'd3, 1'b1, DEV, 8'h23, 8'h00, 8'h00, "R5");
        run_txn(3'd5, 1'b0, DEV, 8'h33, 8'd50, 8'h00, "R6");
        run_txn(3'd5, 1'b0, DEV, 8'h34, 8'd0, 8'h00, "R6");
        rx_q[0] = 8'd33;
        run_txn(3'd5, 1'b1, DEV, 8'h35, 8'h77, 8'h00, "R7");
        rx_q[0] = 8'd32;
        for (int i = 1; i < 33; i++) rx_q[i] = 8'(8'hC0 + i);
        run_txn(3'd5, 1'b1, DEV, 8'h36, 8'h00, 8'h00, "R7");
        run_txn(3'd4, 1'b0, DEV, 8'h00, 8'h00, 8'h00, "R10");
        run_txn(3'd7, 1'b1, DEV, 8'h00, 8'h00, 8'h00, "R10");
        run_txn(3'd2, 1'b0, 7'h15, 8'h44, 8'h01, 8'h00, "R11");

        // R12: control write during a stalled word write is ignored
        slow = 1;
        bus_wr(3'd3, 8'h5E); bus_wr(3'd4, {DEV, 1'b0});
        bus_wr(3'd5, 8'h01); bus_wr(3'd6, 8'h02);
        gen_expected(3'd3, 1'b0, DEV, 8'h5E, 8'h01, 8'h02);
        log_n = 0; agent_rp = 0;
        bus_wr(3'd2, 8'h4C);
        bus_rd(3'd0, v); chk("R3", "busy bit while running", 16'(v[0]), 16'h1);
        bus_wr(3'd2, 8'h40);
        wait_idle();
        slow = 0;
        chk("R12", "op count", 16'(log_n), 16'(exp_n));
        for (int i = 0; i < exp_n && i < log_n; i++)
            chk("R12", "op", 16'({log_kind[i][2:0], log_byte[i][7:0]}),
                16'({exp_kind[i][2:0], exp_byte[i][7:0]}));
        bus_rd(3'd2, v); chk("R12", "control kept", 16'(v), 16'h0C);
        bus_rd(3'd0, v); chk("R3", "done bit", 16'(v), 16'h02);
        bus_wr(3'd0, 8'h00);

        // Constrained random transactions
        for (int t = 0; t < 60; t++) begin
            logic [2:0] p;
            logic r;
            logic [6:0] a7;
            logic [7:0] d0;
            string req;
            if (t % 10 == 0) load_buf(int'($urandom % 256));
            p = plist[$urandom % 12];
            r = 1'($urandom % 2);
            a7 = ($urandom % 8 == 0) ? (DEV ^ 7'h11) : DEV;
            d0 = 8'($urandom);
            if (p == 5 && !r) d0 = 8'($urandom % 40);
            for (int i = 0; i < 64; i++) rx_q[i] = 8'($urandom);
            if (p == 5 && r) rx_q[0] = 8'($urandom % 40);
            if (!(p == 0 || p == 1 || p == 2 || p == 3 || p == 5)) req = "R10";
            else if (a7 != DEV) req = "R11";
            else if (p == 5) req = r ? "R7" : "R6";
            else if (p >= 2) req = "R5";
            else req = "R4";
            run_txn(p, r, a7, 8'($urandom), d0, 8'($urandom), req);
        end

        chk("R13", "idle at end", 16'(op_valid), 16'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule